// File: doc/BRIEF.md
# Destination Address Filter CAM

This block decides whether a received Ethernet frame is for the station by looking only at its 48-bit destination address. It holds sixteen six-byte station addresses, each switched on or off by one bit of a 16-bit enable mask. Three mode bits widen acceptance: promiscuous reception of unicast frames, all multicast frames, or the broadcast address.

A compare strobe presents an address and the mode bits. One clock later the block reports whether the frame is accepted, and flags the acceptance as multicast or broadcast when a mode bit caused it. Entries are written one at a time through an index-plus-value port. The enable mask has its own write strobe.

A read-back port shows the entry chosen by a pointer as three 16-bit words. It does so only while the controller holds the block in reset mode, and returns zero otherwise.

Top module: `addr_filter_cam`

## Requirements
- R1: After reset, all result outputs are 0, the enable mask is 0, and every entry reads back as zero in reset mode.
- R2: With mode bit 0 (promiscuous) set, an address whose group bit (dst_addr_i[0], bit 0 of the first byte, held in bits 7:0) is 0 is accepted with no flag. A group address is not accepted by this mode.
- R3: With mode bit 1 (all multicast) set, an address whose group bit is 1 is accepted with mcast_o set, unless R2 has already decided the frame.
- R4: With mode bit 2 (broadcast) set, an address of all ones is accepted with bcast_o set, unless R2 or R3 has already decided the frame. A group address that is not all ones is not accepted by this mode.
- R5: If no mode accepts the frame, it is accepted with no flag when it equals, exactly, an entry whose enable bit (mask bit i for entry i) is 1. A disabled entry never matches.
- R6: A frame that none of R2 to R5 accepts is rejected: accept_o, mcast_o and bcast_o are all 0.
- R7: At most one flag is set, and a flag is set only together with accept_o. Multicast takes priority over broadcast.
- R8: Results appear, with res_valid_o high, on the clock edge after the one that samples cmp_valid_i. res_valid_o is high for exactly that one cycle, and the results hold their values until the next compare.
- R9: An entry write or mask write in the same cycle as a compare does not change that compare's result. The new value takes part from the next compare on.
- R10: Entry layout: byte k of an address sits in bits 8k+7:8k of load_data_i and dst_addr_i. In reset mode, read-back word n is {byte 2n+1, byte 2n} of the entry that the low 4 bits of rd_ptr_i select. The upper pointer bits are ignored.
- R11: With reset_mode_i low, all three read-back words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_valid_i | input | 1 | Compare strobe |
| dst_addr_i | input | 48 | Destination address, byte k at bits 8k+7:8k |
| mode_i | input | 3 | bit0 promiscuous, bit1 all multicast, bit2 broadcast |
| load_en_i | input | 1 | Entry write strobe |
| load_idx_i | input | 4 | Entry index to write |
| load_data_i | input | 48 | Entry value, same byte layout as the address |
| mask_we_i | input | 1 | Enable mask write strobe |
| mask_i | input | 16 | New enable mask |
| reset_mode_i | input | 1 | Controller reset mode, gates read-back |
| rd_ptr_i | input | 16 | Read-back pointer, low 4 bits used |
| rd_word0_o | output | 16 | Bytes 1:0 of the selected entry |
| rd_word1_o | output | 16 | Bytes 3:2 of the selected entry |
| rd_word2_o | output | 16 | Bytes 5:4 of the selected entry |
| res_valid_o | output | 1 | Result valid pulse |
| accept_o | output | 1 | Frame accepted |
| mcast_o | output | 1 | Accepted by the all-multicast mode |
| bcast_o | output | 1 | Accepted by the broadcast mode |

## Verification
Compares use four kinds of address: unicast addresses that are stored in an enabled entry, stored in a disabled entry, or not stored at all; a multicast address that is not all ones; and the all-ones broadcast address. Each kind is tried under each single mode bit and under mode combinations. This separates the priority order: promiscuous reception limited to unicast, multicast winning over broadcast, and the plain CAM match used only as the fallback. Writes that land in the same cycle as a compare show that the old entry and mask values decide that compare. Read-back is swept with junk in the upper pointer bits and with reset mode both on and off, which exposes the word packing and the gate.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned NUM_WORDS  = ADDR_W / WORD_W;

  localparam int unsigned MODE_W       = 3;
  localparam int unsigned MODE_PROMISC = 0;
  localparam int unsigned MODE_ALLMC   = 1;
  localparam int unsigned MODE_BCAST   = 2;

  typedef struct packed {
    logic accept;
    logic mcast;
    logic bcast;
  } afc_result_t;
endpackage

// File: rtl/afc_entry_bank.sv
module afc_entry_bank
  import afc_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned PTR_W       = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      dst_addr_i,
  input  logic                   load_en_i,
  input  logic [IDX_W-1:0]       load_idx_i,
  input  logic [ADDR_W-1:0]      load_data_i,
  input  logic                   mask_we_i,
  input  logic [NUM_ENTRIES-1:0] mask_i,
  input  logic                   reset_mode_i,
  input  logic [PTR_W-1:0]       rd_ptr_i,
  output logic                   hit_any_o,
  output logic [ADDR_W-1:0]      rd_data_o
);
  logic [ADDR_W-1:0]      entry_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] en_q;
  logic [NUM_ENTRIES-1:0] hit;
  logic [IDX_W-1:0]       rd_sel;
  logic                   unused_ptr_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ENTRIES; i++) entry_q[i] <= '0;
      en_q <= '0;
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++)
        if (load_en_i && load_idx_i == IDX_W'(i)) entry_q[i] <= load_data_i;
      if (mask_we_i) en_q <= mask_i;
    end
  end

  // one comparator per entry, old contents used during a same-cycle write
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign hit[g] = en_q[g] && (entry_q[g] == dst_addr_i);
  end
  assign hit_any_o = |hit;

  assign rd_sel        = rd_ptr_i[IDX_W-1:0];
  assign unused_ptr_hi = |rd_ptr_i[PTR_W-1:IDX_W];
  assign rd_data_o     = reset_mode_i ? entry_q[rd_sel] : '0;

  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> en_q == $past(mask_i));  // R9
  AST_HIT_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit & ~en_q) == '0);  // R5
endmodule

// File: rtl/afc_decide.sv
module afc_decide
  import afc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_valid_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              hit_any_i,
  output logic              res_valid_o,
  output afc_result_t       res_o
);
  logic        group_bit;
  logic        all_ones;
  afc_result_t res_d;

  assign group_bit = dst_addr_i[0];
  assign all_ones  = &dst_addr_i;

  // fixed priority: promiscuous unicast, all multicast, broadcast, CAM
  always_comb begin
    res_d = '0;
    if (mode_i[MODE_PROMISC] && !group_bit) begin
      res_d.accept = 1'b1;
    end else if (mode_i[MODE_ALLMC] && group_bit) begin
      res_d.accept = 1'b1;
      res_d.mcast  = 1'b1;
    end else if (mode_i[MODE_BCAST] && all_ones) begin
      res_d.accept = 1'b1;
      res_d.bcast  = 1'b1;
    end else if (hit_any_i) begin
      res_d.accept = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_o       <= '0;
    end else begin
      res_valid_o <= cmp_valid_i;
      if (cmp_valid_i) res_o <= res_d;
    end
  end

  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_o.mcast && res_o.bcast));  // R7
  AST_FLAG_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o.mcast || res_o.bcast) |-> res_o.accept);  // R7
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i |=> res_valid_o);  // R8
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_valid_i |=> !res_valid_o && $stable(res_o));  // R8
  AST_PROMISC_UNI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i && mode_i[MODE_PROMISC] && !dst_addr_i[0]
      |=> res_o.accept && !res_o.mcast && !res_o.bcast);  // R2
  AST_MCAST_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i && mode_i[MODE_ALLMC] && dst_addr_i[0] |=> res_o.mcast);  // R3
endmodule

// File: rtl/addr_filter_cam.sv
module addr_filter_cam
  import afc_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned PTR_W       = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmp_valid_i,
  input  logic [47:0]            dst_addr_i,
  input  logic [2:0]             mode_i,
  input  logic                   load_en_i,
  input  logic [IDX_W-1:0]       load_idx_i,
  input  logic [47:0]            load_data_i,
  input  logic                   mask_we_i,
  input  logic [NUM_ENTRIES-1:0] mask_i,
  input  logic                   reset_mode_i,
  input  logic [PTR_W-1:0]       rd_ptr_i,
  output logic [15:0]            rd_word0_o,
  output logic [15:0]            rd_word1_o,
  output logic [15:0]            rd_word2_o,
  output logic                   res_valid_o,
  output logic                   accept_o,
  output logic                   mcast_o,
  output logic                   bcast_o
);
  logic              hit_any;
  logic [ADDR_W-1:0] rd_data;
  afc_result_t       res;

  afc_entry_bank #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .PTR_W      (PTR_W)
  ) i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dst_addr_i  (dst_addr_i),
    .load_en_i   (load_en_i),
    .load_idx_i  (load_idx_i),
    .load_data_i (load_data_i),
    .mask_we_i   (mask_we_i),
    .mask_i      (mask_i),
    .reset_mode_i(reset_mode_i),
    .rd_ptr_i    (rd_ptr_i),
    .hit_any_o   (hit_any),
    .rd_data_o   (rd_data)
  );

  afc_decide i_decide (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmp_valid_i(cmp_valid_i),
    .dst_addr_i (dst_addr_i),
    .mode_i     (mode_i),
    .hit_any_i  (hit_any),
    .res_valid_o(res_valid_o),
    .res_o      (res)
  );

  // word n = {byte 2n+1, byte 2n}
  assign rd_word0_o = rd_data[0*WORD_W +: WORD_W];
  assign rd_word1_o = rd_data[1*WORD_W +: WORD_W];
  assign rd_word2_o = rd_data[2*WORD_W +: WORD_W];

  assign accept_o = res.accept;
  assign mcast_o  = res.mcast;
  assign bcast_o  = res.bcast;
endmodule

// File: tb/test_addr_filter_cam.sv
`timescale 1ns/1ps
module test_addr_filter_cam;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmp_valid_i = 1'b0;
  logic [47:0] dst_addr_i = '0;
  logic [2:0]  mode_i = '0;
  logic        load_en_i = 1'b0;
  logic [3:0]  load_idx_i = '0;
  logic [47:0] load_data_i = '0;
  logic        mask_we_i = 1'b0;
  logic [15:0] mask_i = '0;
  logic        reset_mode_i = 1'b0;
  logic [15:0] rd_ptr_i = '0;
  logic [15:0] rd_word0_o, rd_word1_o, rd_word2_o;
  logic        res_valid_o, accept_o, mcast_o, bcast_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [47:0] m_cam [16];
  logic [15:0] m_mask;
  logic e_valid, e_acc, e_mc, e_bc;

  always #2.5 clk_i = ~clk_i;

  addr_filter_cam i_addr_filter_cam (.*);

  task automatic chk(input string tag, input string what, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [47:0] v, input int k);
    return v[8*k +: 8];
  endfunction

  task automatic model_cmp(input logic [47:0] a, input logic [2:0] md);
    bit grp, ones, hit;
    grp = a[0];
    ones = 1;
    for (int k = 0; k < 6; k++) if (byte_of(a, k) != 8'hFF) ones = 0;
    hit = 0;
    for (int i = 0; i < 16; i++) if (m_mask[i] && m_cam[i] == a) hit = 1;
    e_acc = 0; e_mc = 0; e_bc = 0;
    if (md[0] && !grp) e_acc = 1;
    else if (md[1] && grp) begin e_acc = 1; e_mc = 1; end
    else if (md[2] && ones) begin e_acc = 1; e_bc = 1; end
    else if (hit) e_acc = 1;
  endtask

  task automatic check_rb(input string tag);
    logic [15:0] w [3];
    for (int n = 0; n < 3; n++)
      w[n] = reset_mode_i ? {byte_of(m_cam[rd_ptr_i[3:0]], 2*n+1), byte_of(m_cam[rd_ptr_i[3:0]], 2*n)} : 16'h0;
    chk(tag, "rd_word0", {32'h0, rd_word0_o}, {32'h0, w[0]});
    chk(tag, "rd_word1", {32'h0, rd_word1_o}, {32'h0, w[1]});
    chk(tag, "rd_word2", {32'h0, rd_word2_o}, {32'h0, w[2]});
  endtask

  // drive after a falling edge, check read-back, clock, check registered results
  task automatic cyc(input logic cv, input logic [47:0] da, input logic [2:0] md,
                     input logic le, input logic [3:0] li, input logic [47:0] ld,
                     input logic mw, input logic [15:0] mk,
                     input logic rm, input logic [15:0] rp, input string tag);
    cmp_valid_i = cv; dst_addr_i = da; mode_i = md;
    load_en_i = le; load_idx_i = li; load_data_i = ld;
    mask_we_i = mw; mask_i = mk; reset_mode_i = rm; rd_ptr_i = rp;
    #1;
    check_rb(rm ? "R10" : "R11");
    e_valid = cv;
    if (cv) model_cmp(da, md);
    @(posedge clk_i);
    if (le) m_cam[li] = ld;
    if (mw) m_mask = mk;
    @(negedge clk_i);
    chk("R8", "res_valid", {47'h0, res_valid_o}, {47'h0, e_valid});
    chk(tag, "accept", {47'h0, accept_o}, {47'h0, e_acc});
    chk(tag, "mcast", {47'h0, mcast_o}, {47'h0, e_mc});
    chk(tag, "bcast", {47'h0, bcast_o}, {47'h0, e_bc});
  endtask

  task automatic cmp(input logic [47:0] da, input logic [2:0] md, input string tag);
    cyc(1, da, md, 0, 0, '0, 0, '0, 1, 16'h0, tag);
  endtask

  function automatic logic [47:0] ent(input int i);
    return {8'h66, 8'h55, 8'h44, 8'h33, 4'h2, i[3:0], 8'h10};
  endfunction

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCAST = 48'h0000_5E00_0001;
  localparam logic [47:0] UNK   = 48'h0A0B_0C0D_0E02;

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_cam[i] = '0;
    m_mask = '0;
    e_valid = 0; e_acc = 0; e_mc = 0; e_bc = 0;
    repeat (3) @(negedge clk_i);
    chk("R1", "accept in reset", {47'h0, accept_o}, 48'h0);
    chk("R1", "valid in reset", {47'h0, res_valid_o}, 48'h0);
    rst_ni = 1'b1;
    // R1: all entries zero after reset, and no match on a zero address
    for (int i = 0; i < 16; i++) cyc(0, '0, 0, 0, 0, '0, 0, '0, 1, 16'(i), "R1");
    cmp(48'h0, 3'b000, "R1");
    // load entries, read back with junk upper pointer bits (R10)
    for (int i = 0; i < 16; i++) cyc(0, '0, 0, 1, 4'(i), ent(i), 0, '0, 1, 16'hFFF0, "R10");
    for (int i = 0; i < 16; i++) cyc(0, '0, 0, 0, 0, '0, 0, '0, 1, 16'hA5A0 | 16'(i), "R10");
    for (int i = 0; i < 4; i++) cyc(0, '0, 0, 0, 0, '0, 0, '0, 0, 16'(i), "R11");
    cyc(0, '0, 0, 0, 0, '0, 1, 16'h5555, 1, 16'h0, "R5");
    // CAM match: enabled, disabled, unknown
    cmp(ent(4), 3'b000, "R5");
    cmp(ent(5), 3'b000, "R5");
    cmp(UNK, 3'b000, "R6");
    // promiscuous
    cmp(UNK, 3'b001, "R2");
    cmp(MCAST, 3'b001, "R2");
    cmp(ent(5), 3'b001, "R2");
    // all multicast and broadcast priority
    cmp(MCAST, 3'b010, "R3");
    cmp(UNK, 3'b010, "R6");
    cmp(BCAST, 3'b110, "R7");
    cmp(BCAST, 3'b111, "R7");
    cmp(BCAST, 3'b100, "R4");
    cmp(MCAST, 3'b100, "R4");
    cmp(BCAST, 3'b000, "R6");
    cmp(BCAST, 3'b001, "R6");
    // hold between compares
    repeat (3) cyc(0, UNK, 3'b111, 0, 0, '0, 0, '0, 1, 16'h3, "R8");
    cmp(ent(0), 3'b000, "R8");
    cyc(0, '0, 0, 0, 0, '0, 0, '0, 1, 16'h0, "R8");
    // same-cycle writes do not affect the compare
    cyc(1, UNK, 3'b000, 1, 4'd2, UNK, 0, '0, 1, 16'h2, "R9");
    cmp(UNK, 3'b000, "R9");
    cyc(1, UNK, 3'b000, 1, 4'd2, ent(2), 0, '0, 1, 16'h2, "R9");
    cmp(UNK, 3'b000, "R9");
    cyc(1, ent(2), 3'b000, 0, 0, '0, 1, 16'h0000, 1, 16'h2, "R9");
    cmp(ent(2), 3'b000, "R9");
    cyc(1, ent(3), 3'b000, 0, 0, '0, 1, 16'hFFFF, 1, 16'h3, "R9");
    cmp(ent(3), 3'b000, "R5");
    cmp(ent(15), 3'b000, "R5");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule